// File: doc/BRIEF.md
# Dual Counter Start Control Unit

This block holds the run/stop control for a pair of independent up-counters, together with each counter's compare registers, behind a byte-wide register bus. Each channel counts one step per clock while its run flag is set and compares the count with its primary compare register A. On a match the count returns to zero. A per-channel select bit decides whether the hardware then clears the run flag (stop-on-match) or lets the counter keep going (continue mode). A single-cycle match pulse per channel goes to the surrounding logic.

Each channel also has a second compare register B and two further registers C and D. A mode register can make C a buffer for A and D a buffer for B. In that case the buffered value moves into the primary register at the match, so software can stage a new period or compare value without a glitch. Software reaches every register through byte addresses. A 16-bit register occupies two consecutive addresses, with the low byte first.

Top module: `tpc_top`

## Requirements
- R1: After reset the start register reads 0xFC. Both run flags (bit 0 = channel 0, bit 1 = channel 1) are 0, and both mode-select bits (bit 2 = channel 0, bit 3 = channel 1) are 1, which means continue mode.
- R2: After reset the mode register (address 0x01) reads 0x0E. Its bits 3..1 always read as 1. Bit 0 is a plain stored synchronous-operation bit that has no effect on counting.
- R3: Bits 7..4 of the start register (address 0x00) always read as 1, whatever value is written to them.
- R4: A running counter adds one per clock. When a running counter equals its register A, the match output of that channel is high for exactly the next cycle. The first pulse comes A+1 clocks after the start write takes effect, when counting starts from zero.
- R5: When the select bit of a channel is 0 (stop mode), a match clears that channel's run flag and sets its count to zero. No further pulses occur until software sets the run flag again.
- R6: When the select bit of a channel is 1 (continue mode), the count wraps to zero on the clock after the match and keeps counting. The match pulses then repeat every A+1 clocks.
- R7: Mode register bit 4 (channel 0) and bit 6 (channel 1) make register C a buffer for A. On each match, A takes the value of C. A write to C does not change A before that match.
- R8: Mode register bit 5 (channel 0) and bit 7 (channel 1) make register D a buffer for B. On each match of register A, B takes the value of D.
- R9: With buffering off, a write to A, B, C or D takes effect at once and reads back unchanged.
- R10: A software write to the start register in the same cycle as a hardware stop-on-match clear sets the run flags to the written value.
- R11: A read returns its data on rdata one clock after rd_en. Address 0x00 is the start register and 0x01 the mode register. Channel n starts at base 0x10*(n+1), with the following offsets: count at 0/1, A at 2/3, B at 4/5, C at 6/7 and D at 8/9 (low byte first). Every other address reads 0.
- R12: A software write to a count byte replaces that byte and takes precedence over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| match | output | 2 | Per-channel compare-match pulse |

## Verification
The assertions assume that reset is held across the first clock edge. They also assume that software never writes a count byte and a start-register value in ways that the properties do not exclude: each property carries the software-write case in its antecedent. The stimulus writes the start register with a full byte, so the run flags always take a defined value. The random phase keeps compare values between 1 and 30, so a match of A = 0 never produces a continuously high pulse during period measurement. It also zeroes the counter of a channel before starting it, so every measured interval starts from a known count.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  localparam int NUM_CH  = 2;
  localparam int ADDR_W  = 6;
  localparam int BUS_W   = 8;
  localparam int OFS_W   = 4;
  localparam int NUM_FLD = 5;

  localparam logic [ADDR_W-1:0] ADR_START = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_MODE  = 6'h01;

  typedef enum int {
    FLD_CNT = 0,
    FLD_A   = 1,
    FLD_B   = 2,
    FLD_C   = 3,
    FLD_D   = 4
  } fld_e;

  localparam logic [1:0] RUN_RST  = 2'b00;
  localparam logic [1:0] CONT_RST = 2'b11;
endpackage

// File: rtl/tpc_ctrl.sv
module tpc_ctrl
  import tpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [NUM_CH-1:0] evt_i,
  output logic [NUM_CH-1:0] run_o,
  output logic [NUM_CH-1:0] buf_a_o,
  output logic [NUM_CH-1:0] buf_b_o,
  output logic [BUS_W-1:0]  start_rd_o,
  output logic [BUS_W-1:0]  mode_rd_o
);
  logic [NUM_CH-1:0] run_q, cont_q, buf_a_q, buf_b_q;
  logic              sync_q;
  logic              st_wr, md_wr;
  logic              unused_wbits;

  assign st_wr = wr_i && (addr_i == ADR_START);
  assign md_wr = wr_i && (addr_i == ADR_MODE);
  assign unused_wbits = ^wdata_i[3:1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_run
    always_ff @(posedge clk) begin
      if (rst) begin
        run_q[c]  <= RUN_RST[c];
        cont_q[c] <= CONT_RST[c];
      end else if (st_wr) begin
        run_q[c]  <= wdata_i[c];
        cont_q[c] <= wdata_i[NUM_CH + c];
      end else if (evt_i[c] && !cont_q[c]) begin
        run_q[c]  <= 1'b0;
      end
    end

    a_r5_auto_stop: assert property (@(posedge clk) disable iff (rst)
      (evt_i[c] && !cont_q[c] && !st_wr) |=> !run_q[c]);

    a_r6_keeps_running: assert property (@(posedge clk) disable iff (rst)
      (evt_i[c] && cont_q[c] && !st_wr) |=> run_q[c]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= 1'b0;
      buf_a_q <= '0;
      buf_b_q <= '0;
    end else if (md_wr) begin
      sync_q     <= wdata_i[0];
      buf_a_q[0] <= wdata_i[4];
      buf_b_q[0] <= wdata_i[5];
      buf_a_q[1] <= wdata_i[6];
      buf_b_q[1] <= wdata_i[7];
    end
  end

  assign run_o      = run_q;
  assign buf_a_o    = buf_a_q;
  assign buf_b_o    = buf_b_q;
  assign start_rd_o = {4'hF, cont_q, run_q};
  assign mode_rd_o  = {buf_b_q[1], buf_a_q[1], buf_b_q[0], buf_a_q[0], 3'b111, sync_q};

  a_r10_sw_wins: assert property (@(posedge clk) disable iff (rst)
    st_wr |=> (run_q == $past(wdata_i[NUM_CH-1:0])));
endmodule

// File: rtl/tpc_chan.sv
module tpc_chan
  import tpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             buf_a_i,
  input  logic             buf_b_i,
  input  logic             wr_i,
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic             evt_o,
  output logic             match_o,
  output logic [BUS_W-1:0] rd_byte_o
);
  localparam int BYTES = CNT_W / BUS_W;
  localparam int SPAN  = BYTES * NUM_FLD;

  logic [CNT_W-1:0] cnt_q, a_q, b_q, c_q, d_q;
  logic             match_q;
  logic             ofs_ok;
  int               fld, bidx;
  logic             wr_cnt, wr_a, wr_b, wr_c, wr_d;
  logic [CNT_W-1:0] rd_word;

  function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] old,
                                                input int idx,
                                                input logic [BUS_W-1:0] b);
    logic [CNT_W-1:0] r;
    r = old;
    r[idx*BUS_W +: BUS_W] = b;
    return r;
  endfunction

  always_comb begin
    ofs_ok = (int'(ofs_i) < SPAN);
    fld    = int'(ofs_i) / BYTES;
    bidx   = int'(ofs_i) % BYTES;
  end

  assign wr_cnt = wr_i && ofs_ok && (fld == FLD_CNT);
  assign wr_a   = wr_i && ofs_ok && (fld == FLD_A);
  assign wr_b   = wr_i && ofs_ok && (fld == FLD_B);
  assign wr_c   = wr_i && ofs_ok && (fld == FLD_C);
  assign wr_d   = wr_i && ofs_ok && (fld == FLD_D);

  assign evt_o = run_i && (cnt_q == a_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      c_q     <= '0;
      d_q     <= '0;
      match_q <= 1'b0;
    end else begin
      match_q <= evt_o;
      if (wr_cnt)      cnt_q <= put_byte(cnt_q, bidx, wdata_i);
      else if (evt_o)  cnt_q <= '0;
      else if (run_i)  cnt_q <= cnt_q + 1'b1;
      if (wr_a)                   a_q <= put_byte(a_q, bidx, wdata_i);
      else if (evt_o && buf_a_i)  a_q <= c_q;
      if (wr_b)                   b_q <= put_byte(b_q, bidx, wdata_i);
      else if (evt_o && buf_b_i)  b_q <= d_q;
      if (wr_c) c_q <= put_byte(c_q, bidx, wdata_i);
      if (wr_d) d_q <= put_byte(d_q, bidx, wdata_i);
    end
  end

  always_comb begin
    case (fld)
      FLD_CNT: rd_word = cnt_q;
      FLD_A:   rd_word = a_q;
      FLD_B:   rd_word = b_q;
      FLD_C:   rd_word = c_q;
      default: rd_word = d_q;
    endcase
    rd_byte_o = ofs_ok ? rd_word[bidx*BUS_W +: BUS_W] : '0;
  end

  assign match_o = match_q;

  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (run_i && !evt_o && !wr_cnt) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !wr_cnt) |=> $stable(cnt_q));

  a_r6_zero_after_match: assert property (@(posedge clk) disable iff (rst)
    (evt_o && !wr_cnt) |=> (cnt_q == '0));

  a_r4_pulse_follows: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> match_o);

  a_r7_buf_a_load: assert property (@(posedge clk) disable iff (rst)
    (evt_o && buf_a_i && !wr_a) |=> (a_q == $past(c_q)));

  a_r8_buf_b_load: assert property (@(posedge clk) disable iff (rst)
    (evt_o && buf_b_i && !wr_b) |=> (b_q == $past(d_q)));

  a_r9_a_stable: assert property (@(posedge clk) disable iff (rst)
    (!wr_a && !(evt_o && buf_a_i)) |=> $stable(a_q));
endmodule

// File: rtl/tpc_rdmux.sv
module tpc_rdmux
  import tpc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [BUS_W-1:0]              start_i,
  input  logic [BUS_W-1:0]              mode_i,
  input  logic [NUM_CH-1:0][BUS_W-1:0]  chan_i,
  output logic [BUS_W-1:0]              rdata_o
);
  logic [BUS_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr_i == ADR_START)     sel = start_i;
    else if (addr_i == ADR_MODE) sel = mode_i;
    else begin
      for (int c = 0; c < NUM_CH; c++)
        if (int'(addr_i[ADDR_W-1:OFS_W]) == c + 1) sel = chan_i[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= sel;
  end

  a_r11_read_latency: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/tpc_top.sv
module tpc_top
  import tpc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic [NUM_CH-1:0] match
);
  logic [NUM_CH-1:0]             run, buf_a, buf_b, evt;
  logic [BUS_W-1:0]              start_rd, mode_rd;
  logic [NUM_CH-1:0][BUS_W-1:0]  chan_rd;

  tpc_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_i       (wr_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .evt_i      (evt),
    .run_o      (run),
    .buf_a_o    (buf_a),
    .buf_b_o    (buf_b),
    .start_rd_o (start_rd),
    .mode_rd_o  (mode_rd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = (int'(addr[ADDR_W-1:OFS_W]) == c + 1);

    tpc_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .run_i     (run[c]),
      .buf_a_i   (buf_a[c]),
      .buf_b_i   (buf_b[c]),
      .wr_i      (wr_en && sel),
      .ofs_i     (addr[OFS_W-1:0]),
      .wdata_i   (wdata),
      .evt_o     (evt[c]),
      .match_o   (match[c]),
      .rd_byte_o (chan_rd[c])
    );
  end

  tpc_rdmux u_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (rd_en),
    .addr_i  (addr),
    .start_i (start_rd),
    .mode_i  (mode_rd),
    .chan_i  (chan_rd),
    .rdata_o (rdata)
  );
endmodule

// File: tb/sim_tpc_top.sv
module sim_tpc_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] match;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tpc_top u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
              .wdata(wdata), .rdata(rdata), .match(match));

  function automatic int exp_period(input int cmp);
    return cmp + 1;
  endfunction

  function automatic logic [5:0] reg_adr(input int ch, input int fld);
    return 6'((ch + 1) * 16 + fld * 2);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output int d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = int'(rdata);
  endtask

  task automatic wr16(input logic [5:0] a, input int v);
    bus_wr(a, 8'(v));
    bus_wr(a + 6'd1, 8'(v >> 8));
  endtask

  task automatic wait_pulse(input int ch, input int lim, output int n);
    bit got = 0;
    n = -1;
    for (int i = 1; i <= lim && !got; i++) begin
      @(negedge clk);
      if (match[ch]) begin n = i; got = 1; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion (all requirements)");
    finish_run();
  end

  initial begin
    int d, n, cnt;
    int unsigned seed_set;
    seed_set = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 / R2 reset values
    bus_rd(6'h00, d); chk("R1 start reset", d, 8'hFC);
    bus_rd(6'h01, d); chk("R2 mode reset", d, 8'h0E);

    // R3 unused start bits, R2 mode readback
    bus_wr(6'h00, 8'h0C); bus_rd(6'h00, d); chk("R3 upper bits read 1", d, 8'hFC);
    bus_wr(6'h00, 8'h00); bus_rd(6'h00, d); chk("R3 after zero write", d, 8'hF0);
    bus_wr(6'h01, 8'h00); bus_rd(6'h01, d); chk("R2 bits 3..1 read 1", d, 8'h0E);
    bus_wr(6'h01, 8'h01); bus_rd(6'h01, d); chk("R2 sync bit stored", d, 8'h0F);
    bus_wr(6'h01, 8'h00);

    // R9 immediate register writes, R11 unmapped reads
    wr16(reg_adr(0, 1), 16'h1234);
    bus_rd(reg_adr(0, 1), d); chk("R9 A0 low", d, 8'h34);
    bus_rd(reg_adr(0, 1) + 6'd1, d); chk("R9 A0 high", d, 8'h12);
    wr16(reg_adr(1, 4), 16'hBEEF);
    bus_rd(reg_adr(1, 4), d); chk("R9 D1 low", d, 8'hEF);
    bus_rd(reg_adr(1, 4) + 6'd1, d); chk("R9 D1 high", d, 8'hBE);
    bus_rd(6'h1F, d); chk("R11 unmapped channel offset", d, 0);
    bus_rd(6'h05, d); chk("R11 unmapped low address", d, 0);
    bus_rd(6'h3A, d); chk("R11 unmapped high address", d, 0);

    // R4 / R5 stop-on-match, channel 0
    wr16(reg_adr(0, 1), 5);
    bus_wr(6'h00, 8'h01);
    wait_pulse(0, 50, n); chk("R4 first pulse delay", n, exp_period(5));
    cnt = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (match[0]) cnt++; end
    chk("R5 no pulses after stop", cnt, 0);
    bus_rd(6'h00, d); chk("R5 run flag cleared", d, 8'hF0);
    bus_rd(reg_adr(0, 0), d); chk("R5 count zero", d, 0);

    // R6 continue mode, channel 1
    wr16(reg_adr(1, 1), 3);
    bus_wr(6'h00, 8'h0A);
    for (int k = 0; k < 3; k++) begin
      wait_pulse(1, 50, n); chk("R6 repeat period", n, exp_period(3));
    end
    bus_wr(6'h00, 8'h08);

    // R12 count byte write overrides counting, channel 1
    wr16(reg_adr(1, 0), 16'h0102);
    bus_rd(reg_adr(1, 0), d); chk("R12 count low write", d, 8'h02);
    wr16(reg_adr(1, 0), 0);
    wr16(reg_adr(1, 1), 16'h00FF);
    bus_wr(6'h00, 8'h0A);
    bus_wr(reg_adr(1, 0), 8'h50);
    wait_pulse(1, 400, n); chk("R12 count jump while running", n, 16'h00FF - 16'h0050 + 1);
    bus_wr(6'h00, 8'h08);

    // R10 software write beats hardware clear, channel 0 stop mode
    wr16(reg_adr(0, 1), 2);
    bus_wr(6'h00, 8'h01);
    @(negedge clk);
    bus_wr(6'h00, 8'h01);
    cnt = match[0] ? 1 : 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (match[0]) cnt++; end
    chk("R10 run survives collision (pulse count)", cnt, 2);
    bus_rd(6'h00, d); chk("R10 stopped afterwards", d, 8'hF0);

    // R7 / R8 buffered compare, channel 0
    bus_wr(6'h01, 8'h30);
    wr16(reg_adr(0, 1), 4);
    wr16(reg_adr(0, 3), 9);
    wr16(reg_adr(0, 2), 16'h0011);
    wr16(reg_adr(0, 4), 16'h0022);
    bus_rd(reg_adr(0, 1), d); chk("R7 A unchanged by C write", d, 4);
    bus_wr(6'h00, 8'h05);
    wait_pulse(0, 50, n); chk("R7 first period uses old A", n, exp_period(4));
    wait_pulse(0, 50, n); chk("R7 second period uses C", n, exp_period(9));
    bus_rd(reg_adr(0, 1), d); chk("R7 A loaded from C", d, 9);
    bus_rd(reg_adr(0, 2), d); chk("R8 B loaded from D", d, 8'h22);
    bus_wr(6'h00, 8'h0C);
    bus_wr(6'h01, 8'h00);

    // Random periods, buffered and unbuffered, both channels (R6, R7)
    for (int it = 0; it < 8; it++) begin
      int ch, av, cv;
      bit bf;
      ch = it % 2;
      bf = it[1];
      av = int'($urandom_range(30, 1));
      cv = int'($urandom_range(30, 1));
      bus_wr(6'h00, 8'h0C);
      wr16(reg_adr(ch, 0), 0);
      bus_wr(6'h01, bf ? (ch == 1 ? 8'h40 : 8'h10) : 8'h00);
      wr16(reg_adr(ch, 1), av);
      wr16(reg_adr(ch, 3), cv);
      bus_wr(6'h00, 8'(8'h0C | (1 << ch)));
      wait_pulse(ch, 100, n); chk("R6 random first period", n, exp_period(av));
      wait_pulse(ch, 100, n);
      chk(bf ? "R7 random buffered period" : "R6 random unbuffered period",
          n, bf ? exp_period(cv) : exp_period(av));
    end
    bus_wr(6'h00, 8'h0C);

    finish_run();
  end
endmodule